// File: doc/BRIEF.md
# Multi-Mode Interrupt Controller

This block gathers up to 32 interrupt sources and reduces them to two CPU request lines and a wakeup signal. Each source has its own three-bit trigger mode, which selects rising edges, falling edges, both edges, a high level, a low level, or all four together. It also has a mask bit, a wakeup-enable bit and a routing bit that picks which of the two request lines it drives. Edge events are held in two status words, one for rising edges and one for falling edges, until software clears them. Level conditions are not held: they follow the input.

Software reaches the block through a simple word-addressed register port with a combinational read. Each configuration word has a read/set address and a separate clear address, so single bits can be changed without a read-modify-write. A one-bit test register can replace the pin of any source whose source-select bit is 0, so the whole path can be exercised with no peripheral attached. Pins are synchronized by two flops before detection.

Top module: `irq_ctrl`

## Requirements
- R1: For each of the seven configuration words (mode bit planes 0/1/2, source select, routing, wakeup, mask), writing 1s at the set address sets those bits and writing 1s at the clear address clears them. Written 0 bits change nothing. The set address reads back the word. Byte addresses are: plane0 0x00/0x04, plane1 0x08/0x0C, plane2 0x10/0x14, select 0x18/0x1C, routing 0x20/0x24, wakeup 0x28/0x2C, mask 0x30/0x34.
- R2: The mode of source n is {plane2[n], plane1[n], plane0[n]}. Mode 001 reacts to rising edges, 010 to falling edges and 011 to both. A detected edge stays latched and keeps the source active.
- R3: Mode 101 makes the source active while its input is high, and mode 110 while its input is low. Level activity is not latched.
- R4: Modes 000 and 100 disable the source. It never becomes active and its edges are not latched.
- R5: Mode 111 enables both levels and both edges.
- R6: A source-select bit of 1 takes the source from its pin. A bit of 0 takes it from the test bit, which is bit 0 of the word at 0x40.
- R7: A routing bit of 1 sends the source to request 0, and 0 sends it to request 1. A source never appears on both.
- R8: Only sources whose mask bit is 1 reach the status words and the request lines.
- R9: The wakeup output is high when at least one unmasked active source has its wakeup bit set.
- R10: The rising-edge latches (0x38) and falling-edge latches (0x3C) read back, and writing 1s there clears them. A new edge in the same cycle as its clear leaves the latch set.
- R11: The status words at 0x44 (request 0) and 0x48 (request 1) read back the active, unmasked sources, equal to the status outputs. Each request line is the OR of its status word.
- R12: Reset clears every configuration word, the test bit and both latch words, so every output is 0.
- R13: A pin change reaches a level source's request line after two rising clock edges. The edge latch is written one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | N | Asynchronous source pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Byte address for read and write |
| wdata_i | input | N | Write data |
| rdata_o | output | N | Read data for addr_i (combinational) |
| req0_o | output | 1 | CPU request line 0 |
| req1_o | output | 1 | CPU request line 1 |
| act0_o | output | N | Active unmasked sources routed to request 0 |
| act1_o | output | N | Active unmasked sources routed to request 1 |
| wake_o | output | 1 | Wakeup-from-idle request |

## Verification
The assertions check on every cycle that the status words never overlap, that masked or disabled sources never appear in them, that a raised wakeup always has a wakeup-enabled active source behind it, that set and clear writes change the mask word exactly as R1 defines, and that a fresh edge always lands in its latch. Only the bench's scenarios can show the mode decode for each of the eight codes against real pin sequences. The same holds for the test-bit substitution, the synchronizer latency, and the same-cycle race between a latch clear and a new edge, because these depend on stimulus timing.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // configuration words held as set/clear pairs; pair p: set word 2p, clear word 2p+1
  localparam int NPAIR   = 7;
  localparam int P_CFG0  = 0;
  localparam int P_CFG1  = 1;
  localparam int P_CFG2  = 2;
  localparam int P_SRC   = 3;
  localparam int P_ROUTE = 4;
  localparam int P_WAKE  = 5;
  localparam int P_MASK  = 6;

  // plain words following the pairs
  localparam int W_RISE  = 14;
  localparam int W_FALL  = 15;
  localparam int W_TEST  = 16;
  localparam int W_ACT0  = 17;
  localparam int W_ACT1  = 18;

  typedef struct packed {
    logic rise;
    logic fall;
    logic high;
    logic low;
  } trig_t;

  // mode code {c2,c1,c0}: which trigger conditions it enables
  function automatic trig_t decode_trig(input logic [2:0] m);
    trig_t t;
    t.rise = m[0] & (~m[2] | m[1]);
    t.fall = m[1] & (~m[2] | m[0]);
    t.high = m[2] & m[0];
    t.low  = m[2] & m[1];
    return t;
  endfunction

  // one bit of a set/clear register pair
  function automatic logic set_clr_bit(input logic cur, input logic d,
                                       input logic set_hit, input logic clr_hit);
    logic n;
    n = cur;
    if (set_hit && d) n = 1'b1;
    if (clr_hit && d) n = 1'b0;
    return n;
  endfunction

  // held event with write-1-to-clear; a fresh event outranks the clear
  function automatic logic latch_next(input logic held, input logic clr, input logic evt);
    return (held & ~clr) | evt;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  logic [STAGES-1:0][N-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s_i,
  input  logic         test_i,
  input  logic [N-1:0] srcsel_i,
  input  logic [N-1:0] cfg0_i,
  input  logic [N-1:0] cfg1_i,
  input  logic [N-1:0] cfg2_i,
  input  logic [N-1:0] rise_lat_i,
  input  logic [N-1:0] fall_lat_i,
  output logic [N-1:0] new_rise_o,
  output logic [N-1:0] new_fall_o,
  output logic [N-1:0] active_o,
  output logic [N-1:0] mode_on_o
);

  logic [N-1:0] cur;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    trig_t t;
    assign t             = decode_trig({cfg2_i[i], cfg1_i[i], cfg0_i[i]});
    assign cur[i]        = srcsel_i[i] ? pin_s_i[i] : test_i;
    assign new_rise_o[i] = t.rise & cur[i] & ~prev_q[i];
    assign new_fall_o[i] = t.fall & ~cur[i] & prev_q[i];
    assign active_o[i]   = (t.rise & rise_lat_i[i]) | (t.fall & fall_lat_i[i]) |
                           (t.high & cur[i]) | (t.low & ~cur[i]);
    assign mode_on_o[i]  = t.rise | t.fall | t.high | t.low;
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int WW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [WW-1:0]            widx_i,
  input  logic [N-1:0]             wdata_i,
  input  logic [N-1:0]             new_rise_i,
  input  logic [N-1:0]             new_fall_i,
  input  logic [N-1:0]             act0_i,
  input  logic [N-1:0]             act1_i,
  output logic [NPAIR-1:0][N-1:0]  pair_o,
  output logic [N-1:0]             rise_lat_o,
  output logic [N-1:0]             fall_lat_o,
  output logic                     test_o,
  output logic [N-1:0]             rdata_o
);

  logic [NPAIR-1:0][N-1:0] pair_q;
  logic [N-1:0]            rise_q, fall_q;
  logic                    test_q;
  logic                    rise_hit, fall_hit, test_hit;
  logic [N-1:0]            rise_clr, fall_clr;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic set_hit, clr_hit;
    assign set_hit = wr_en_i && (widx_i == WW'(2*g));
    assign clr_hit = wr_en_i && (widx_i == WW'(2*g+1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pair_q[g] <= '0;
      else begin
        for (int b = 0; b < N; b++)
          pair_q[g][b] <= set_clr_bit(pair_q[g][b], wdata_i[b], set_hit, clr_hit);
      end
    end
  end

  assign rise_hit = wr_en_i && (widx_i == WW'(W_RISE));
  assign fall_hit = wr_en_i && (widx_i == WW'(W_FALL));
  assign test_hit = wr_en_i && (widx_i == WW'(W_TEST));
  assign rise_clr = rise_hit ? wdata_i : '0;
  assign fall_clr = fall_hit ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      test_q <= 1'b0;
    end else begin
      for (int b = 0; b < N; b++) begin
        rise_q[b] <= latch_next(rise_q[b], rise_clr[b], new_rise_i[b]);
        fall_q[b] <= latch_next(fall_q[b], fall_clr[b], new_fall_i[b]);
      end
      if (test_hit) test_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPAIR; p++)
      if (widx_i == WW'(2*p)) rdata_o = pair_q[p];
    if (widx_i == WW'(W_RISE)) rdata_o = rise_q;
    if (widx_i == WW'(W_FALL)) rdata_o = fall_q;
    if (widx_i == WW'(W_TEST)) rdata_o = {{(N-1){1'b0}}, test_q};
    if (widx_i == WW'(W_ACT0)) rdata_o = act0_i;
    if (widx_i == WW'(W_ACT1)) rdata_o = act1_i;
  end

  assign pair_o     = pair_q;
  assign rise_lat_o = rise_q;
  assign fall_lat_o = fall_q;
  assign test_o     = test_q;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_pin_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  rdata_o,
  output logic          req0_o,
  output logic          req1_o,
  output logic [N-1:0]  act0_o,
  output logic [N-1:0]  act1_o,
  output logic          wake_o
);

  localparam int WW = AW - 2;

  logic                    aligned, wr_hit;
  logic [WW-1:0]           widx;
  logic [N-1:0]            pin_s;
  logic [NPAIR-1:0][N-1:0] pair;
  logic [N-1:0]            rise_lat, fall_lat;
  logic                    test_bit;
  logic [N-1:0]            new_rise, new_fall, active, mode_on;
  logic [N-1:0]            mask, route, wake;
  logic [N-1:0]            act0, act1, reg_rdata;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr_hit  = wr_en_i & aligned;
  assign widx    = addr_i[AW-1:2];

  irq_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_pin_i), .q_o(pin_s)
  );

  irq_regs #(.N(N), .WW(WW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_hit), .widx_i(widx), .wdata_i(wdata_i),
    .new_rise_i(new_rise), .new_fall_i(new_fall), .act0_i(act0), .act1_i(act1),
    .pair_o(pair), .rise_lat_o(rise_lat), .fall_lat_o(fall_lat),
    .test_o(test_bit), .rdata_o(reg_rdata)
  );

  irq_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_s_i(pin_s), .test_i(test_bit),
    .srcsel_i(pair[P_SRC]), .cfg0_i(pair[P_CFG0]), .cfg1_i(pair[P_CFG1]),
    .cfg2_i(pair[P_CFG2]), .rise_lat_i(rise_lat), .fall_lat_i(fall_lat),
    .new_rise_o(new_rise), .new_fall_o(new_fall), .active_o(active),
    .mode_on_o(mode_on)
  );

  assign mask  = pair[P_MASK];
  assign route = pair[P_ROUTE];
  assign wake  = pair[P_WAKE];

  assign act0 = active & mask & route;
  assign act1 = active & mask & ~route;

  assign act0_o  = act0;
  assign act1_o  = act1;
  assign req0_o  = |act0;
  assign req1_o  = |act1;
  assign wake_o  = |((act0 | act1) & wake);
  assign rdata_o = aligned ? reg_rdata : '0;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int N  = 32,
  parameter int WW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_hit,
  input logic [WW-1:0] widx,
  input logic [N-1:0]  wdata,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  wake,
  input logic [N-1:0]  mode_on,
  input logic [N-1:0]  act0,
  input logic [N-1:0]  act1,
  input logic [N-1:0]  new_rise,
  input logic [N-1:0]  rise_lat,
  input logic          wake_o
);

  assert_mask_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && widx == WW'(2*P_MASK)) |=> (mask == ($past(mask) | $past(wdata))));

  assert_mask_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && widx == WW'(2*P_MASK+1)) |=> (mask == ($past(mask) & ~$past(wdata))));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((act0 | act1) & ~mode_on) == '0);

  assert_route_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act0 & act1) == '0);

  assert_unmasked_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((act0 | act1) & ~mask) == '0);

  assert_wake_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (((act0 | act1) & wake) != '0));

  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (new_rise != '0) |=> ((rise_lat & $past(new_rise)) == $past(new_rise)));

endmodule

bind irq_ctrl irq_ctrl_chk #(.N(N), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .widx(widx), .wdata(wdata_i),
  .mask(mask), .wake(wake), .mode_on(mode_on), .act0(act0), .act1(act1),
  .new_rise(new_rise), .rise_lat(rise_lat), .wake_o(wake_o)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;

  localparam logic [7:0] A_C0S = 8'h00, A_C0C = 8'h04, A_C1S = 8'h08, A_C1C = 8'h0C;
  localparam logic [7:0] A_C2S = 8'h10, A_C2C = 8'h14, A_SRS = 8'h18, A_SRC = 8'h1C;
  localparam logic [7:0] A_RTS = 8'h20, A_RTC = 8'h24, A_WKS = 8'h28, A_WKC = 8'h2C;
  localparam logic [7:0] A_MKS = 8'h30, A_MKC = 8'h34, A_RISE = 8'h38, A_FALL = 8'h3C;
  localparam logic [7:0] A_TEST = 8'h40, A_ACT0 = 8'h44, A_ACT1 = 8'h48;

  // {mode[2:0], pin before, pin after, expected req0}
  localparam logic [5:0] VEC [0:15] = '{
    6'b001_0_1_1, 6'b001_1_0_0, 6'b010_0_1_0, 6'b010_1_0_1,
    6'b011_0_1_1, 6'b011_1_0_1, 6'b101_1_1_1, 6'b101_0_0_0,
    6'b101_0_1_1, 6'b110_0_0_1, 6'b110_1_1_0, 6'b110_1_0_1,
    6'b111_1_1_1, 6'b111_0_0_1, 6'b000_0_1_0, 6'b100_0_1_0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_pin = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, act0, act1;
  logic        req0, req1, wake;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(irq_pin), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .req0_o(req0), .req1_o(req1),
    .act0_o(act0), .act1_o(act1), .wake_o(wake)
  );

  task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [31:0] bitv, input logic [2:0] m);
    wr(A_C0C, bitv); wr(A_C1C, bitv); wr(A_C2C, bitv);
    if (m[0]) wr(A_C0S, bitv);
    if (m[1]) wr(A_C1S, bitv);
    if (m[2]) wr(A_C2S, bitv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    string tag;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R12: everything clear after reset
    rd(A_MKS, r);  check("R12 mask", r, 0);
    rd(A_C0S, r);  check("R12 plane0", r, 0);
    rd(A_RISE, r); check("R12 rise latch", r, 0);
    check("R12 outputs", {29'd0, req0, req1, wake}, 0);

    // R1: set/clear pairs on the mask word (upper sources have mode 000)
    wr(A_MKS, 32'hF000_0000); rd(A_MKS, r); check("R1 set", r, 32'hF000_0000);
    wr(A_MKS, 32'h0F00_0000); rd(A_MKS, r); check("R1 set more", r, 32'hFF00_0000);
    wr(A_MKC, 32'h3000_0000); rd(A_MKS, r); check("R1 clear", r, 32'hCF00_0000);
    wr(A_MKS, 32'h0);         rd(A_MKS, r); check("R1 zero write", r, 32'hCF00_0000);
    wr(A_MKC, 32'hFFFF_FFFF); rd(A_MKS, r); check("R1 clear all", r, 0);

    // table: source 0 from its pin, routed to request 0, unmasked
    wr(A_SRS, 1); wr(A_RTS, 1); wr(A_MKS, 1);
    for (int v = 0; v < 16; v++) begin
      logic [2:0] m;
      m = VEC[v][5:3];
      set_mode(1, 3'b000);
      irq_pin[0] = VEC[v][2];
      wait_cyc(4);
      wr(A_RISE, 1); wr(A_FALL, 1);
      set_mode(1, m);
      irq_pin[0] = VEC[v][1];
      wait_cyc(5);
      if (m[1:0] == 2'b00)  tag = "R4 disabled mode";
      else if (m == 3'b111) tag = "R5 all triggers";
      else if (m[2])        tag = "R3 level mode";
      else                  tag = "R2 edge mode";
      check($sformatf("%s %b", tag, m), {31'd0, req0}, {31'd0, VEC[v][0]});
    end

    // R4: disabled source latches no edge
    set_mode(1, 3'b000); wr(A_RISE, 1);
    irq_pin[0] = 1'b0; wait_cyc(4); irq_pin[0] = 1'b1; wait_cyc(5);
    rd(A_RISE, r); check("R4 no latch", r, 0);

    // R13: level latency through synchronizer
    set_mode(1, 3'b101);
    irq_pin[0] = 1'b0; wait_cyc(4);
    irq_pin[0] = 1'b1;
    @(posedge clk); @(negedge clk); check("R13 after one edge", {31'd0, req0}, 0);
    @(posedge clk); @(negedge clk); check("R13 after two edges", {31'd0, req0}, 1);

    // R10: latch, clear, and edge beating a same-cycle clear
    irq_pin[0] = 1'b0; wait_cyc(4);
    set_mode(1, 3'b001); wr(A_RISE, 1); wr(A_FALL, 1);
    irq_pin[0] = 1'b1; wait_cyc(5);
    rd(A_RISE, r); check("R10 latched", r, 1);
    wr(A_RISE, 1); rd(A_RISE, r); check("R10 cleared", r, 0);
    irq_pin[0] = 1'b0; wait_cyc(5);
    irq_pin[0] = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    addr = A_RISE; wdata = 1; wr_en = 1'b1;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    rd(A_RISE, r); check("R10 edge wins over clear", r, 1);
    set_mode(1, 3'b000); wr(A_RISE, 1);

    // R6: source 1 from the test bit, then from its pin
    wr(A_SRC, 2); set_mode(2, 3'b101); wr(A_MKS, 2); wr(A_RTS, 2);
    irq_pin[1] = 1'b1; wait_cyc(4);
    check("R6 pin ignored when test selected", act0, 0);
    wr(A_TEST, 1);
    check("R6 test bit drives source", act0, 32'h2);
    wr(A_TEST, 0);
    check("R6 test bit low", act0, 0);
    wr(A_SRS, 2); wait_cyc(1);
    check("R6 pin selected", act0, 32'h2);

    // R7 / R11: routing to request 1 and status words
    wr(A_RTC, 2);
    check("R7 status request 1", act1, 32'h2);
    check("R7 lines", {30'd0, req0, req1}, 32'h1);
    rd(A_ACT1, r); check("R11 status word 1", r, 32'h2);
    rd(A_ACT0, r); check("R11 status word 0", r, 0);

    // R8: mask blocks the source
    wr(A_MKC, 2);
    check("R8 masked", {act1[30:0], req1}, 0);

    // R9: wakeup gating
    wr(A_MKS, 2);
    check("R9 no wake enable", {31'd0, wake}, 0);
    wr(A_WKS, 2);
    check("R9 wake enabled", {31'd0, wake}, 1);
    wr(A_WKC, 2);
    check("R9 wake cleared", {31'd0, wake}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule